// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is a single channel of a periodic timer. Software sees four 32-bit word registers on a simple register bus: a reload constant, the live counter, a control word and a capture word. While the channel's start input is high, a prescaler divides the system clock by a power of four picked in the control word. Each prescaler tick decrements the counter.

When the counter is at zero and a tick arrives, the counter loads the reload constant instead of wrapping, and a sticky underflow flag is set. The flag stays set until software writes the control word with the flag bit at zero. Writing a one to the flag bit has no effect on it. The interrupt output is a level: it is high while both the flag and the interrupt-enable bit are set.

The capture word is plain read/write storage. Reads are registered: the data for a read strobe appears on the read data port one cycle later.

Top module: `rtm_channel`

## Requirements
- R1: After reset the reload constant and the counter each read 0xFFFFFFFF, the control word and the capture word read 0, and irq is low.
- R2: Bus byte address 0x0 selects the reload constant, 0x4 the counter, 0x8 the control word and 0xC the capture word. An access whose address is not a multiple of four is ignored. On a cycle with bus_re high, the register value present before that clock edge appears on bus_rdata after the edge, and bus_rdata then holds until the next read.
- R3: Control bits [2:0] select the prescaler. Codes 0 to 4 give a tick every 4, 16, 64, 256 and 1024 clock cycles respectively. After start rises, the first tick comes on the 4^(code+1)-th rising edge at which start is sampled high. Each tick with a nonzero counter decrements it by one.
- R4: A tick with the counter at zero loads the reload constant into the counter (the value held before that edge) and sets the underflow flag at the same edge.
- R5: The underflow flag reads as control bit 8. A control write with bit 8 at 0 clears it. A write with bit 8 at 1 leaves it unchanged, so it never sets it. If an underflow and a clearing write fall on the same edge, the flag ends up set.
- R6: While start is low the counter holds its value, and the prescaler phase returns to zero. A restart therefore waits a full prescale period before the first tick.
- R7: irq is high exactly when the underflow flag and the interrupt enable (control bit 5) are both set. It changes at the same edge as either of them.
- R8: A bus write to the counter loads the written value at that edge. It overrides any decrement or reload in the same cycle, and no underflow is flagged in that cycle.
- R9: Prescaler codes 5, 6 and 7 produce no ticks, so the counter does not change while they are selected.
- R10: Control bits [7:0] read back as last written. Bit 8 is the flag. Bits [31:9] always read 0, whatever was written. The capture word stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Counting gate; high lets the prescaler run |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: flag AND enable |

## Verification
The bench aims at the reload edge. A counter that wrapped to all ones, or loaded a reload value written in the same cycle, would show the wrong count on the read that follows. It checks that a flag-bit write of one does not set the flag and that a write of zero clears it. A design treating that bit as ordinary data would raise irq with no underflow, or keep it up after a clear. Restarts after a stop are timed to the edge: a prescaler that kept its phase would tick several cycles early. A counter write landing exactly on an underflow tick is checked too, because giving the decrement priority there would load the wrong value and raise a false flag. Reserved prescaler codes are held for a long window to confirm the counter is frozen.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  // Word index of each register (byte address bits [3:2]).
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } rtm_reg_e;

  localparam int CTL_KEEP_W = 8;          // writable control bits [7:0]
  localparam int CTL_IE_BIT = 5;          // interrupt enable
  localparam int CTL_UF_BIT = CTL_KEEP_W; // underflow flag position
  localparam int PSC_CODES  = 5;          // number of usable prescaler codes
  localparam int PSC_SEL_W  = 3;          // prescaler select field width
endpackage

// File: rtl/rtm_prescaler.sv
module rtm_prescaler #(
  parameter int CODES = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = 2 * CODES;

  logic [DIV_W-1:0] div_q;
  logic [CODES-1:0] hit;
  logic             tick_sel;

  // One shared phase counter; stopping the channel returns it to zero.
  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // Code c fires when the low 2c+2 phase bits are all ones.
  for (genvar c = 0; c < CODES; c++) begin : g_hit
    assign hit[c] = &div_q[2*c+1:0];
  end

  always_comb begin
    tick_sel = 1'b0;
    for (int c = 0; c < CODES; c++) begin
      if (sel == SEL_W'(c)) tick_sel = hit[c];
    end
  end

  assign tick = run & tick_sel;
endmodule

// File: rtl/rtm_downcounter.sv
module rtm_downcounter #(
  parameter int              W       = 32,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_q,
  output logic         underflow
);
  logic at_zero;
  assign at_zero   = (cnt_q == '0);
  assign underflow = tick & ~ld_en & at_zero;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= RST_VAL;
    else if (ld_en)     cnt_q <= ld_val;
    else if (underflow) cnt_q <= reload;
    else if (tick)      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rtm_ctrl.sv
module rtm_ctrl #(
  parameter int KEEP_W = 8,
  parameter int IE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [KEEP_W:0]   wr_bits,
  input  logic              uf_set,
  output logic [KEEP_W-1:0] ctrl_q,
  output logic              flag_q,
  output logic              irq_q
);
  logic [KEEP_W-1:0] ctrl_n;
  logic              flag_n;

  always_comb begin
    ctrl_n = wr_en ? wr_bits[KEEP_W-1:0] : ctrl_q;
    // Hardware set beats a software clear on the same edge.
    if (uf_set)                      flag_n = 1'b1;
    else if (wr_en && !wr_bits[KEEP_W]) flag_n = 1'b0;
    else                             flag_n = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      flag_q <= flag_n;
      irq_q  <= flag_n & ctrl_n[IE_BIT];
    end
  end
endmodule

// File: rtl/rtm_channel.sv
module rtm_channel
  import rtm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic              acc_ok;
  rtm_reg_e          idx;
  logic              wr_reload, wr_count, wr_ctrl, wr_capt;
  logic [DATA_W-1:0] reload_q, capt_q, cnt_q;
  logic [CTL_KEEP_W-1:0] ctrl_q;
  logic              flag_q;
  logic              tick, underflow;
  logic [DATA_W-1:0] ctrl_view;

  assign acc_ok = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  assign idx    = rtm_reg_e'(bus_addr[3:2]);

  assign wr_reload = bus_we && acc_ok && (idx == REG_RELOAD);
  assign wr_count  = bus_we && acc_ok && (idx == REG_COUNT);
  assign wr_ctrl   = bus_we && acc_ok && (idx == REG_CTRL);
  assign wr_capt   = bus_we && acc_ok && (idx == REG_CAPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= ONES;
      capt_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_capt)   capt_q   <= bus_wdata;
    end
  end

  rtm_prescaler #(.CODES(PSC_CODES), .SEL_W(PSC_SEL_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (start),
    .sel  (ctrl_q[PSC_SEL_W-1:0]),
    .tick (tick)
  );

  rtm_downcounter #(.W(DATA_W), .RST_VAL(ONES)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ld_en     (wr_count),
    .ld_val    (bus_wdata),
    .reload    (reload_q),
    .cnt_q     (cnt_q),
    .underflow (underflow)
  );

  rtm_ctrl #(.KEEP_W(CTL_KEEP_W), .IE_BIT(CTL_IE_BIT)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ctrl),
    .wr_bits (bus_wdata[CTL_UF_BIT:0]),
    .uf_set  (underflow),
    .ctrl_q  (ctrl_q),
    .flag_q  (flag_q),
    .irq_q   (irq)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTL_KEEP_W-1:0] = ctrl_q;
    ctrl_view[CTL_UF_BIT]     = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re && acc_ok) begin
      unique case (idx)
        REG_RELOAD: bus_rdata <= reload_q;
        REG_COUNT:  bus_rdata <= cnt_q;
        REG_CTRL:   bus_rdata <= ctrl_view;
        REG_CAPT:   bus_rdata <= capt_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtm_channel_chk.sv
module rtm_channel_chk #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int CODES  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              tick,
  input logic              underflow,
  input logic              wr_count,
  input logic              wr_ctrl,
  input logic              clr_bit,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] reload,
  input logic [SEL_W-1:0]  sel,
  input logic              flag,
  input logic              ie,
  input logic              irq
);
  a_r7_irq_needs_both: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && ie));

  a_r7_irq_when_both: assert property (@(posedge clk) disable iff (rst)
    (flag && ie) |-> irq);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_ctrl && !clr_bit)) |=> flag);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    underflow |=> flag);

  a_r6_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!start && !wr_count) |=> $stable(cnt));

  a_r6_no_tick_stopped: assert property (@(posedge clk) disable iff (rst)
    !start |-> !tick);

  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    underflow |=> (cnt == $past(reload)));

  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_count && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> (cnt == $past(wdata)));

  a_r8_no_flag_on_write: assert property (@(posedge clk) disable iff (rst)
    (wr_count && !flag) |=> !flag);

  a_r9_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (sel >= SEL_W'(CODES)) |-> !tick);
endmodule

bind rtm_channel rtm_channel_chk #(
  .DATA_W (DATA_W),
  .SEL_W  (rtm_pkg::PSC_SEL_W),
  .CODES  (rtm_pkg::PSC_CODES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .tick      (tick),
  .underflow (underflow),
  .wr_count  (wr_count),
  .wr_ctrl   (wr_ctrl),
  .clr_bit   (bus_wdata[rtm_pkg::CTL_UF_BIT]),
  .wdata     (bus_wdata),
  .cnt       (cnt_q),
  .reload    (reload_q),
  .sel       (ctrl_q[rtm_pkg::PSC_SEL_W-1:0]),
  .flag      (flag_q),
  .ie        (ctrl_q[rtm_pkg::CTL_IE_BIT]),
  .irq       (irq)
);

// File: tb/rtm_channel_bench.sv
module rtm_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bus_re = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  rtm_channel u_rtm_channel (
    .clk(clk), .rst(rst), .start(start), .bus_re(bus_re), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state, derived from the requirements.
  logic [31:0] m_reload, m_cnt, m_cap, m_rdata;
  logic [7:0]  m_ctrl;
  logic        m_flag, m_irq;
  logic [9:0]  m_div;
  logic        m_tick, m_cwr, m_uf;

  function automatic logic f_tick(input logic [9:0] div, input logic [2:0] code);
    // R3/R9: period 4^(code+1); codes 5..7 never tick
    if (code > 3'd4) return 1'b0;
    return ((div & ((10'd4 << (2*code)) - 10'd1)) == ((10'd4 << (2*code)) - 10'd1));
  endfunction

  function automatic logic [31:0] f_read(input logic [1:0] w);
    case (w)
      2'd0: return m_reload;
      2'd1: return m_cnt;
      2'd2: return {23'd0, m_flag, m_ctrl};
      default: return m_cap;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reload = '1; m_cnt = '1; m_cap = '0; m_rdata = '0;
      m_ctrl = '0; m_flag = 1'b0; m_irq = 1'b0; m_div = '0;
    end else begin
      m_tick = start && f_tick(m_div, m_ctrl[2:0]);
      m_div  = start ? m_div + 10'd1 : 10'd0;
      if (bus_re && bus_addr[1:0] == 2'b00) m_rdata = f_read(bus_addr[3:2]);
      m_cwr = bus_we && bus_addr == 4'h4;
      m_uf  = m_tick && !m_cwr && m_cnt == 0;
      if (m_cwr)         m_cnt = bus_wdata;
      else if (m_uf)     m_cnt = m_reload;
      else if (m_tick)   m_cnt = m_cnt - 32'd1;
      if (m_uf) m_flag = 1'b1;
      else if (bus_we && bus_addr == 4'h8 && !bus_wdata[8]) m_flag = 1'b0;
      if (bus_we && bus_addr == 4'h8) m_ctrl = bus_wdata[7:0];
      if (bus_we && bus_addr == 4'h0) m_reload = bus_wdata;
      if (bus_we && bus_addr == 4'hC) m_cap = bus_wdata;
      m_irq = m_flag & m_ctrl[5];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R7 irq level", {31'd0, irq}, {31'd0, m_irq});
      chk("R2 read data", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    rd(4'h0, v); chk("R1 reload reset", v, 32'hFFFF_FFFF);
    rd(4'h4, v); chk("R1 counter reset", v, 32'hFFFF_FFFF);
    rd(4'h8, v); chk("R1 control reset", v, 32'h0);
    rd(4'hC, v); chk("R1 capture reset", v, 32'h0);

    // R10 capture storage and control readback masking
    wr(4'hC, 32'hA5C3_1234); rd(4'hC, v); chk("R10 capture", v, 32'hA5C3_1234);
    wr(4'h8, 32'hFFFF_FEF8); rd(4'h8, v); chk("R10 control mask", v, 32'h0000_00F8);
    // R2 misaligned write ignored
    wr(4'h9, 32'h0000_0011); rd(4'h8, v); chk("R2 misaligned ignored", v, 32'h0000_00F8);

    // R3/R4/R7: code 0, counter 1, reload 3
    wr(4'h0, 32'd3); wr(4'h4, 32'd1); wr(4'h8, 32'h20);
    start = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'h4, v); chk("R3 first tick at 4th edge", v, 32'd0);
    repeat (2) @(negedge clk);
    chk("R4 no flag before underflow", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R7 irq on underflow", {31'd0, irq}, 32'd1);
    rd(4'h8, v); chk("R4 flag set", v, 32'h120);
    rd(4'h4, v); chk("R4 reload value", v, 32'd3);
    start = 1'b0;

    // R5 flag write semantics
    wr(4'h8, 32'h120); rd(4'h8, v); chk("R5 write one keeps flag", v, 32'h120);
    chk("R5 irq kept", {31'd0, irq}, 32'd1);
    wr(4'h8, 32'h020);
    chk("R5 irq cleared", {31'd0, irq}, 32'd0);
    rd(4'h8, v); chk("R5 flag cleared", v, 32'h020);
    wr(4'h8, 32'h120); rd(4'h8, v); chk("R5 write one never sets", v, 32'h020);

    // R6 hold while stopped
    wr(4'h4, 32'd2);
    repeat (50) @(negedge clk);
    rd(4'h4, v); chk("R6 counter frozen", v, 32'd2);

    // R6 restart waits a full period (code 1 = /16)
    wr(4'h8, 32'h21); wr(4'h4, 32'd0); wr(4'h0, 32'd7);
    start = 1'b1;
    repeat (10) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rd(4'h4, v); chk("R6 no tick in partial period", v, 32'd0);
    start = 1'b1;
    repeat (15) @(negedge clk);
    chk("R6 no tick before full period", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R6 tick after full period", {31'd0, irq}, 32'd1);
    start = 1'b0;

    // R8 counter write on the underflow edge
    wr(4'h8, 32'h20); wr(4'h4, 32'd0); wr(4'h0, 32'd9);
    start = 1'b1;
    repeat (3) @(negedge clk);
    wr(4'h4, 32'd5);
    chk("R8 no flag on write edge", {31'd0, irq}, 32'd0);
    rd(4'h4, v); chk("R8 write wins", v, 32'd5);
    start = 1'b0;

    // R9 reserved codes frozen
    wr(4'h8, 32'h25); wr(4'h4, 32'd10);
    start = 1'b1;
    repeat (100) @(negedge clk);
    rd(4'h4, v); chk("R9 code 5 frozen", v, 32'd10);
    start = 1'b0;
    wr(4'h8, 32'h27);
    start = 1'b1;
    repeat (100) @(negedge clk);
    rd(4'h4, v); chk("R9 code 7 frozen", v, 32'd10);
    start = 1'b0;

    // R3 slowest code (/1024)
    wr(4'h8, 32'h24); wr(4'h4, 32'd1);
    start = 1'b1;
    repeat (1022) @(negedge clk);
    rd(4'h4, v);  chk("R3 before 1024th edge", v, 32'd1);
    @(negedge clk);
    rd(4'h4, v2); chk("R3 at 1024th edge", v2, 32'd0);

    // Random mix checked against the reference every cycle
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      if (($urandom % 16) == 0) start = ~start;
      bus_re = (($urandom % 3) == 0);
      bus_we = (($urandom % 4) == 0);
      bus_addr = {2'($urandom % 4), 2'b00};
      if (($urandom % 20) == 0) bus_addr[0] = 1'b1;
      r = $urandom;
      if (bus_addr[3:2] == 2'd2) begin
        r[2:0] = (($urandom % 4) != 0) ? 3'($urandom % 2) : 3'($urandom % 8);
      end else if (bus_addr[3:2] != 2'd3) begin
        r = $urandom % 8;
      end
      bus_wdata = r;
      @(negedge clk);
    end
    bus_we = 1'b0; bus_re = 1'b0; start = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule